// File: doc/BRIEF.md
# Stepped-Table Waveform Source for a Parallel DAC

This block produces a periodic waveform as a stream of 8-bit codes for a parallel-input DAC and generates that converter's active-low write strobe. Three shapes are available: a sine read from a 256-entry table, a triangle computed from the phase index, and a two-level pulse. A single point counter times everything. Each table point, or each pulse level, occupies one interval of clock cycles. Within that interval the new code is presented first, the strobe is pulsed low for a fixed time, and the bus then stays quiet until the next point.

Three key inputs, each already debounced, select the shape. Frequency is set by the interval between points rather than by a phase increment. After reset the block plays a slow sine. The sine key selects a fast sine. The triangle key keeps whatever interval is in use. The pulse key uses separate high and low durations. A selection made part way through a point is held pending and is applied when the next point starts. The bipolar output is Vout = (code - 128)/128 x Vref, so code 128 is the zero level.

Top module: `wavegen`

## Requirements
- R1: While `rst` is high and on the first point after it, `dac_data` is 128 and `dac_wr_n` is high. The block then plays a sine from phase 0 with an interval of max(STEP_SLOW, MIN) cycles, where MIN = SETUP_CYC + STROBE_LOW_CYC + HOLD_CYC.
- R2: The sine code at phase p (0..255) is 128 + f(p) for p < 128 and 128 - f(p - 128) otherwise, with f(x) = floor(x*(128-x)*127 / 4096).
- R3: The triangle code at phase p is 2p for p < 128 and 255 - 2(p - 128) otherwise.
- R4: In pulse mode the code alternates between 255, held for max(PULSE_HIGH, MIN) cycles, and 0, held for max(PULSE_LOW, MIN) cycles. The first point after entering pulse mode is 255.
- R5: Each point drives exactly one strobe. The strobe goes low SETUP_CYC cycles after the point starts and stays low for exactly STROBE_LOW_CYC cycles, so consecutive falling edges are one interval apart.
- R6: `dac_data` changes only at the start of a point. At that moment `dac_wr_n` is high and has been high for at least HOLD_CYC cycles. The code is stable for at least SETUP_CYC cycles before the strobe falls and for the whole low time.
- R7: Any configured interval shorter than MIN is raised to MIN.
- R8: `key_sine` selects sine with interval max(STEP_FAST, MIN). `key_tri` selects triangle and keeps the table interval currently selected. `key_pulse` selects pulse.
- R9: If several keys are high in the same cycle, sine takes priority over triangle, and triangle over pulse.
- R10: A key press never alters the point in progress, neither its code nor its interval. The new selection applies from the next point.
- R11: A change of shape restarts the table phase at 0. Re-selecting the current shape continues the phase without a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_sine | input | 1 | Select fast sine (debounced) |
| key_tri | input | 1 | Select triangle (debounced) |
| key_pulse | input | 1 | Select pulse (debounced) |
| dac_data | output | 8 | Code presented to the DAC |
| dac_wr_n | output | 1 | Active-low DAC write strobe |

## Verification
The timing assertions rely on the keys being clean, synchronous levels, and on no interval being shorter than MIN. The block itself enforces the second condition by clamping. The bench drives each key for one cycle only, away from the clock edge. It deliberately sets the fast step below MIN so that the clamp decides the interval. Every key press is placed just after a strobe falls, which leaves several cycles before the next point starts and makes the hand-off at the point boundary deterministic.

// File: rtl/wavegen.sv
module wavegen #(
  parameter int SETUP_CYC      = 12,
  parameter int STROBE_LOW_CYC = 63,
  parameter int HOLD_CYC       = 12,
  parameter int STEP_SLOW      = 20345,
  parameter int STEP_FAST      = 4883,
  parameter int PULSE_HIGH     = 20000,
  parameter int PULSE_LOW      = 20000,
  parameter int CNT_W          = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_sine,
  input  logic       key_tri,
  input  logic       key_pulse,
  output logic [7:0] dac_data,
  output logic       dac_wr_n
);

  localparam int MIN_IVL = SETUP_CYC + STROBE_LOW_CYC + HOLD_CYC;
  localparam logic [CNT_W-1:0] IV_SLOW = CNT_W'(STEP_SLOW  < MIN_IVL ? MIN_IVL : STEP_SLOW);
  localparam logic [CNT_W-1:0] IV_FAST = CNT_W'(STEP_FAST  < MIN_IVL ? MIN_IVL : STEP_FAST);
  localparam logic [CNT_W-1:0] IV_HI   = CNT_W'(PULSE_HIGH < MIN_IVL ? MIN_IVL : PULSE_HIGH);
  localparam logic [CNT_W-1:0] IV_LO   = CNT_W'(PULSE_LOW  < MIN_IVL ? MIN_IVL : PULSE_LOW);
  localparam logic [CNT_W-1:0] LO_BEG  = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] LO_END  = CNT_W'(SETUP_CYC + STROBE_LOW_CYC);

  localparam logic [1:0] M_SINE = 2'd0, M_TRI = 2'd1, M_PULSE = 2'd2;

  function automatic logic [7:0] sine_at(input int p);
    int x, f;
    x = p % 128;
    f = (x * (128 - x) * 127) >>> 12;
    return (p < 128) ? 8'(128 + f) : 8'(128 - f);
  endfunction

  logic [7:0] rom [256];
  for (genvar g = 0; g < 256; g++) begin : g_rom
    assign rom[g] = sine_at(g);
  end

  logic [1:0]       mode_q, pend_mode;
  logic [CNT_W-1:0] pend_step, ivl_q, cnt_q, cnt_nxt;
  logic [7:0]       phase_q, nphase, tri_code, ncode;
  logic             level_q, nlevel, boundary, chg;
  logic [CNT_W-1:0] nivl;

  assign boundary = (cnt_q == ivl_q - 1'b1);
  assign cnt_nxt  = boundary ? '0 : cnt_q + 1'b1;
  assign chg      = (pend_mode != mode_q);
  assign nphase   = chg ? 8'd0 : phase_q + 8'd1;
  assign nlevel   = chg ? 1'b1 : ~level_q;
  assign tri_code = nphase[7] ? 8'(8'd255 - {nphase[6:0], 1'b0}) : {nphase[6:0], 1'b0};
  assign ncode    = (pend_mode == M_PULSE) ? {8{nlevel}} :
                    (pend_mode == M_TRI)   ? tri_code : rom[nphase];
  assign nivl     = (pend_mode == M_PULSE) ? (nlevel ? IV_HI : IV_LO) : pend_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode <= M_SINE;
      pend_step <= IV_SLOW;
    end else if (key_sine) begin
      pend_mode <= M_SINE;
      pend_step <= IV_FAST;
    end else if (key_tri) begin
      pend_mode <= M_TRI;
    end else if (key_pulse) begin
      pend_mode <= M_PULSE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_SINE;
      ivl_q    <= IV_SLOW;
      cnt_q    <= '0;
      phase_q  <= 8'd0;
      level_q  <= 1'b0;
      dac_data <= 8'd128;
      dac_wr_n <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      dac_wr_n <= !((cnt_nxt >= LO_BEG) && (cnt_nxt < LO_END));
      if (boundary) begin
        mode_q   <= pend_mode;
        ivl_q    <= nivl;
        phase_q  <= nphase;
        level_q  <= nlevel;
        dac_data <= ncode;
      end
    end
  end

  logic [7:0]  d_prev_q;
  logic        wr_prev_q;
  logic [15:0] since_chg_q, since_rise_q, low_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_prev_q     <= 8'd128;
      wr_prev_q    <= 1'b1;
      since_chg_q  <= '1;
      since_rise_q <= '1;
      low_run_q    <= '0;
    end else begin
      d_prev_q     <= dac_data;
      wr_prev_q    <= dac_wr_n;
      since_chg_q  <= (dac_data != d_prev_q) ? 16'd1 :
                      (&since_chg_q) ? since_chg_q : since_chg_q + 16'd1;
      since_rise_q <= (dac_wr_n && !wr_prev_q) ? 16'd1 :
                      (&since_rise_q) ? since_rise_q : since_rise_q + 16'd1;
      low_run_q    <= dac_wr_n ? 16'd0 : low_run_q + 16'd1;
    end
  end

  assert_low_width_R5: assert property (@(posedge clk) disable iff (rst)
    (dac_wr_n && !wr_prev_q) |-> (low_run_q == 16'(STROBE_LOW_CYC)));

  assert_setup_before_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (!dac_wr_n && wr_prev_q) |-> (since_chg_q >= 16'(SETUP_CYC)));

  assert_change_only_high_R6: assert property (@(posedge clk) disable iff (rst)
    (dac_data != d_prev_q) |-> (dac_wr_n && wr_prev_q && since_rise_q >= 16'(HOLD_CYC)));

  assert_stable_while_low_R6: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> $stable(dac_data));

  assert_pulse_levels_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PULSE) |-> (dac_data == 8'd0 || dac_data == 8'd255));

  assert_switch_at_point_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> (cnt_q == '0));

  assert_interval_floor_R7: assert property (@(posedge clk) disable iff (rst)
    ivl_q >= CNT_W'(MIN_IVL));

endmodule

// File: tb/sim_wavegen.sv
module sim_wavegen;
  localparam int SU = 3, LW = 5, HD = 2, MINV = SU + LW + HD;
  localparam int SLOW = 40, FAST = 6, PHI = 12, PLO = 20;

  logic clk = 0, rst = 1, ks = 0, kt = 0, kp = 0;
  logic [7:0] dac_data;
  logic dac_wr_n;
  always #4 clk = ~clk;

  wavegen #(.SETUP_CYC(SU), .STROBE_LOW_CYC(LW), .HOLD_CYC(HD), .STEP_SLOW(SLOW),
            .STEP_FAST(FAST), .PULSE_HIGH(PHI), .PULSE_LOW(PLO), .CNT_W(16)) u0 (
    .clk(clk), .rst(rst), .key_sine(ks), .key_tri(kt), .key_pulse(kp),
    .dac_data(dac_data), .dac_wr_n(dac_wr_n));

  int checks = 0, fails = 0, cyc = 0, nlat = 0;
  int lat_code [4096];
  int lat_t [4096];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int sine_ref(input int p);
    int x = p % 128;
    int f = (x * (128 - x) * 127) / 4096;
    return (p < 128) ? 128 + f : 128 - f;
  endfunction

  function automatic int tri_ref(input int p);
    return (p < 128) ? 2 * p : 255 - 2 * (p - 128);
  endfunction

  // Timing monitor: R5 strobe width, R6 data placement
  logic [7:0] prev_data;
  logic prev_wr;
  int since_chg, since_rise, low_len;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      since_chg = 100; since_rise = 100; low_len = 0;
      prev_wr = 1; prev_data = dac_data; nlat = 0;
    end else begin
      since_chg++; since_rise++;
      if (dac_data != prev_data) begin
        chk(prev_wr && dac_wr_n && since_rise >= HD, "R6 change while strobe high", since_rise, HD);
        since_chg = 0;
      end
      if (prev_wr && !dac_wr_n) begin
        chk(since_chg >= SU, "R6 setup before strobe", since_chg, SU);
        low_len = 1;
        if (nlat < 4096) begin
          lat_code[nlat] = dac_data; lat_t[nlat] = cyc;
        end
        nlat++;
      end else if (!prev_wr && !dac_wr_n) begin
        low_len++;
      end else if (!prev_wr && dac_wr_n) begin
        chk(low_len == LW, "R5 strobe low width", low_len, LW);
        since_rise = 0;
      end
      prev_wr = dac_wr_n; prev_data = dac_data;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wait_lat(input int n);
    while (nlat < n) @(negedge clk);
  endtask

  task automatic after_fall(output int m);
    int n0 = nlat;
    while (nlat == n0) @(negedge clk);
    m = nlat - 1;
  endtask

  task automatic press(input bit s, input bit t, input bit p);
    ks = s; kt = t; kp = p;
    @(negedge clk);
    ks = 0; kt = 0; kp = 0;
  endtask

  function automatic int gap(input int i);
    return lat_t[i + 1] - lat_t[i];
  endfunction

  task automatic t_reset;
    rst = 1;
    repeat (5) @(negedge clk);
    chk(dac_wr_n == 1'b1, "R1 strobe high in reset", int'(dac_wr_n), 1);
    chk(dac_data == 8'd128, "R1 zero code in reset", dac_data, 128);
    rst = 0;
  endtask

  task automatic t_default_sine;
    wait_lat(5);
    for (int i = 0; i < 5; i++) chk(lat_code[i] == sine_ref(i), "R1 R2 slow sine code", lat_code[i], sine_ref(i));
    for (int i = 0; i < 4; i++) chk(gap(i) == SLOW, "R1 slow interval", gap(i), SLOW);
  endtask

  task automatic t_sine_key;
    int m;
    after_fall(m);
    press(1, 0, 0);
    wait_lat(m + 258);
    chk(gap(m) == SLOW, "R10 point in progress keeps interval", gap(m), SLOW);
    for (int i = m + 1; i <= m + 256; i++)
      chk(lat_code[i] == sine_ref(i % 256), "R2 R11 sine continues", lat_code[i], sine_ref(i % 256));
    for (int i = m + 1; i < m + 257; i++)
      chk(gap(i) == MINV, "R7 R8 fast step clamped", gap(i), MINV);
  endtask

  task automatic t_tri;
    int m;
    after_fall(m);
    press(0, 1, 0);
    wait_lat(m + 258);
    chk(gap(m) == MINV, "R10 interval before triangle", gap(m), MINV);
    for (int i = 0; i < 256; i++)
      chk(lat_code[m + 1 + i] == tri_ref(i), "R3 R11 triangle code", lat_code[m + 1 + i], tri_ref(i));
    for (int i = m + 1; i < m + 257; i++)
      chk(gap(i) == MINV, "R8 triangle keeps interval", gap(i), MINV);
  endtask

  task automatic t_pulse;
    int m;
    after_fall(m);
    press(0, 0, 1);
    wait_lat(m + 8);
    for (int i = 0; i < 6; i++) begin
      chk(lat_code[m + 1 + i] == ((i % 2 == 0) ? 255 : 0), "R4 pulse level",
          lat_code[m + 1 + i], (i % 2 == 0) ? 255 : 0);
      chk(gap(m + 1 + i) == ((i % 2 == 0) ? PHI : PLO), "R4 pulse duration",
          gap(m + 1 + i), (i % 2 == 0) ? PHI : PLO);
    end
  endtask

  task automatic t_priority;
    int m, b, old;
    after_fall(m);
    old = (lat_code[m] == 255) ? PHI : PLO;
    press(1, 1, 1);
    wait_lat(m + 6);
    chk(gap(m) == old, "R10 pulse level finishes", gap(m), old);
    for (int i = 0; i < 4; i++) begin
      chk(lat_code[m + 1 + i] == sine_ref(i), "R9 R11 sine wins from phase 0", lat_code[m + 1 + i], sine_ref(i));
      chk(gap(m + 1 + i) == MINV, "R9 fast sine interval", gap(m + 1 + i), MINV);
    end
    b = m + 1;
    after_fall(m);
    press(1, 0, 0);
    wait_lat(m + 4);
    for (int i = m + 1; i < m + 4; i++)
      chk(lat_code[i] == sine_ref((i - b) % 256), "R11 same shape continues", lat_code[i], sine_ref((i - b) % 256));
  endtask

  task automatic t_tri_slow;
    int m;
    t_reset;
    after_fall(m);
    press(0, 1, 0);
    wait_lat(m + 5);
    chk(lat_code[m] == 128, "R1 first point after reset", lat_code[m], 128);
    for (int i = 0; i < 3; i++) begin
      chk(lat_code[m + 1 + i] == tri_ref(i), "R3 triangle after reset", lat_code[m + 1 + i], tri_ref(i));
      chk(gap(m + 1 + i) == SLOW, "R8 triangle keeps slow interval", gap(m + 1 + i), SLOW);
    end
  endtask

  initial begin
    t_reset;
    t_default_sine;
    t_sine_key;
    t_tri;
    t_pulse;
    t_priority;
    t_tri_slow;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule